// File: doc/BRIEF.md
# DDR3 Burst Beat Order Generator

This block turns one read or write burst command into the column order of its data beats. A command gives the three low start-column bits, a read/write flag, an ordering select (sequential or interleaved), a two-bit burst-length mode and a per-command chop bit. After the block accepts the command, it steps through eight beat slots, one per clock.

In each slot the block presents the slot index and the column of the beat carried in that slot. A drive flag marks the slots that carry real data. In slots that are blanked by burst chop, the flag is low and the column reads zero. The drive flag is meant to enable the data and strobe output drivers for reads and the capture path for writes.

For writes, a one-cycle marker shows where the internal write operation is taken to begin. A downstream timer uses it as the reference point for write recovery and write-to-read spacing. That point moves two slots earlier when chop is fixed by the mode setting, but not when chop is chosen per command.

Top module: `ddr_beat_order`

## Requirements
- R1: A command is accepted on a clock edge where `start_i` is high and `busy_o` is low. Beat slot 0 appears in the cycle that follows. `busy_o` stays high for exactly eight cycles, in which `beat_idx_o` counts 0 to 7. After that `busy_o` falls.
- R2: A `start_i` pulse while `busy_o` is high is ignored, and the running burst goes on with the command fields it latched. Changes to the command inputs during a burst have no effect on it.
- R3: `bl_mode_i` is decoded as follows. 2'b00 is fixed length 8. 2'b01 is on-the-fly, where `otf_chop_i`=1 selects chop-4 and 0 selects length 8. 2'b10 is fixed chop-4. The reserved value 2'b11 behaves as fixed length 8.
- R4: Sequential read of length 8: slot k carries column `{c[2]^k[2], (c[1:0]+k[1:0]) mod 4}`. Start 1 gives 1,2,3,0,5,6,7,4.
- R5: Interleaved read of length 8: slot k carries column `c XOR k`. Start 5 gives 5,4,7,6,1,0,3,2.
- R6: Chopped read: slots 0 to 3 carry the columns of R4 or R5 with `beat_drive_o`=1. Slots 4 to 7 have `beat_drive_o`=0 and `beat_col_o`=0.
- R7: Write of length 8: slot k carries column k whatever the start column and ordering select are.
- R8: Chopped write: slots 0 to 3 carry `{c[2], k[1:0]}`, so only start bit 2 matters. Slots 4 to 7 have `beat_drive_o`=0 and `beat_col_o`=0.
- R9: For a write, `wr_end_o` pulses for one cycle, in slot 5 when chop is fixed by mode 2'b10 and in slot 7 otherwise (including on-the-fly chop). It never pulses for a read.
- R10: During and right after reset, and whenever idle, `busy_o`, `beat_drive_o` and `wr_end_o` are 0, and `beat_idx_o` and `beat_col_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| wr_i | input | 1 | 1 = write, 0 = read |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| bl_mode_i | input | 2 | Burst-length mode (see R3) |
| otf_chop_i | input | 1 | Per-command chop select, used in mode 2'b01 |
| col_i | input | 3 | Start column low bits |
| busy_o | output | 1 | High during the eight beat slots |
| beat_idx_o | output | 3 | Current slot index |
| beat_col_o | output | 3 | Column of the beat in this slot |
| beat_drive_o | output | 1 | Slot carries a driven beat |
| wr_end_o | output | 1 | Internal write start marker |

## Verification
A wrong latched command or a bad mode decode shows on `beat_col_o` in slot 0, or at the latest in slot 4 where group order and chop blanking first differ. So every burst is checked slot by slot against orders computed in the bench. A fault in the slot counter shows as a wrong `beat_idx_o` or as `busy_o` falling on the wrong edge, within the same burst. A misplaced write marker is off by two slots, and it is seen in the burst that caused it. Bursts with start pulses injected mid-burst confirm that a command hitting a busy generator leaves no trace at the ports.

// File: rtl/ddr_beat_pkg.sv
package ddr_beat_pkg;
  parameter int unsigned COL_W = 3;
  localparam int unsigned BURST_BEATS = 1 << COL_W;

  typedef enum logic [1:0] {
    BL_FIXED8 = 2'b00,
    BL_OTF    = 2'b01,
    BL_FIXED4 = 2'b10,
    BL_RSVD   = 2'b11
  } bl_mode_e;

  typedef struct packed {
    logic             wr;
    logic             ilv;
    logic             chop;
    logic             early_end;
    logic [COL_W-1:0] col;
  } burst_cmd_t;
endpackage

// File: rtl/ddr_beat_cmd_latch.sv
module ddr_beat_cmd_latch
  import ddr_beat_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             wr_i,
  input  logic             ilv_i,
  input  bl_mode_e         mode_i,
  input  logic             otf_chop_i,
  input  logic [COL_W-1:0] col_i,
  output burst_cmd_t       cmd_o
);
  burst_cmd_t cmd_d;

  always_comb begin
    cmd_d.wr   = wr_i;
    cmd_d.ilv  = ilv_i;
    cmd_d.col  = col_i;
    unique case (mode_i)
      BL_FIXED4: cmd_d.chop = 1'b1;
      BL_OTF:    cmd_d.chop = otf_chop_i;
      default:   cmd_d.chop = 1'b0; // fixed 8 and reserved
    endcase
    // pull-in only when chop comes from the mode setting
    cmd_d.early_end = wr_i && (mode_i == BL_FIXED4);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_o <= '0;
    else if (load_i) cmd_o <= cmd_d;
  end
endmodule

// File: rtl/ddr_beat_slot_ctr.sv
module ddr_beat_slot_ctr #(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = {IDX_W{1'b1}};

  assign accept_o = start_i && !busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      idx_o  <= '0;
    end else if (accept_o) begin
      busy_o <= 1'b1;
      idx_o  <= '0;
    end else if (busy_o) begin
      if (idx_o == LAST) begin
        busy_o <= 1'b0;
        idx_o  <= '0;
      end else begin
        idx_o <= idx_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/ddr_beat_col_gen.sv
module ddr_beat_col_gen
  import ddr_beat_pkg::*;
(
  input  logic             busy_i,
  input  burst_cmd_t       cmd_i,
  input  logic [COL_W-1:0] idx_i,
  output logic [COL_W-1:0] col_o,
  output logic             drive_o
);
  localparam int unsigned MSB  = COL_W - 1;
  localparam int unsigned LO_W = COL_W - 1;

  logic [COL_W-1:0] rd_seq, rd_ilv, wr_col, sel;
  logic             tail;

  // group bit swaps, low bits wrap inside the group
  assign rd_seq = {cmd_i.col[MSB] ^ idx_i[MSB], LO_W'(cmd_i.col[LO_W-1:0] + idx_i[LO_W-1:0])};
  assign rd_ilv = cmd_i.col ^ idx_i;
  assign wr_col = cmd_i.chop ? {cmd_i.col[MSB], idx_i[LO_W-1:0]} : idx_i;
  assign tail   = idx_i[MSB];

  always_comb begin
    if (cmd_i.wr)       sel = wr_col;
    else if (cmd_i.ilv) sel = rd_ilv;
    else                sel = rd_seq;
  end

  assign drive_o = busy_i && !(cmd_i.chop && tail);
  assign col_o   = drive_o ? sel : '0;
endmodule

// File: rtl/ddr_beat_wr_mark.sv
module ddr_beat_wr_mark
  import ddr_beat_pkg::*;
#(
  parameter int unsigned WR_PULL_IN = 2
) (
  input  logic             busy_i,
  input  burst_cmd_t       cmd_i,
  input  logic [COL_W-1:0] idx_i,
  output logic             wr_end_o
);
  localparam logic [COL_W-1:0] SLOT_LATE  = COL_W'(BURST_BEATS - 1);
  localparam logic [COL_W-1:0] SLOT_EARLY = COL_W'(BURST_BEATS - 1 - WR_PULL_IN);

  logic [COL_W-1:0] target;
  assign target   = cmd_i.early_end ? SLOT_EARLY : SLOT_LATE;
  assign wr_end_o = busy_i && cmd_i.wr && (idx_i == target);
endmodule

// File: rtl/ddr_beat_order.sv
module ddr_beat_order
  import ddr_beat_pkg::*;
#(
  parameter int unsigned WR_PULL_IN = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_i,
  input  logic             interleave_i,
  input  logic [1:0]       bl_mode_i,
  input  logic             otf_chop_i,
  input  logic [COL_W-1:0] col_i,
  output logic             busy_o,
  output logic [COL_W-1:0] beat_idx_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_drive_o,
  output logic             wr_end_o
);
  logic       accept;
  burst_cmd_t cmd_q;

  ddr_beat_slot_ctr #(.IDX_W(COL_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .busy_o  (busy_o),
    .idx_o   (beat_idx_o)
  );

  ddr_beat_cmd_latch u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (accept),
    .wr_i      (wr_i),
    .ilv_i     (interleave_i),
    .mode_i    (bl_mode_e'(bl_mode_i)),
    .otf_chop_i(otf_chop_i),
    .col_i     (col_i),
    .cmd_o     (cmd_q)
  );

  ddr_beat_col_gen u_col (
    .busy_i (busy_o),
    .cmd_i  (cmd_q),
    .idx_i  (beat_idx_o),
    .col_o  (beat_col_o),
    .drive_o(beat_drive_o)
  );

  ddr_beat_wr_mark #(.WR_PULL_IN(WR_PULL_IN)) u_mark (
    .busy_i  (busy_o),
    .cmd_i   (cmd_q),
    .idx_i   (beat_idx_o),
    .wr_end_o(wr_end_o)
  );
endmodule

// File: rtl/ddr_beat_order_chk.sv
module ddr_beat_order_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       wr_i,
  input logic [1:0] bl_mode_i,
  input logic       busy_o,
  input logic [2:0] beat_idx_o,
  input logic [2:0] beat_col_o,
  input logic       beat_drive_o,
  input logic       wr_end_o
);
  p_first_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o && beat_idx_o == 3'd0);

  p_end_burst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && beat_idx_o == 3'd7 |=> !busy_o);

  p_ignore_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && beat_idx_o != 3'd7 |=> busy_o && beat_idx_o == 3'($past(beat_idx_o) + 3'd1));

  p_blank_stays_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !beat_drive_o && beat_idx_o != 3'd7 |=> !beat_drive_o);

  p_wr8_first_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && wr_i && bl_mode_i == 2'b00 |=> beat_drive_o && beat_col_o == 3'd0);

  p_wr_end_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_end_o |=> !wr_end_o);

  p_idle_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !beat_drive_o && !wr_end_o && beat_col_o == 3'd0 && beat_idx_o == 3'd0);
endmodule

bind ddr_beat_order ddr_beat_order_chk u_chk (.*);

// File: tb/ddr_beat_order_bench.sv
`timescale 1ns/1ps
module ddr_beat_order_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       interleave_i = 1'b0;
  logic [1:0] bl_mode_i = 2'b00;
  logic       otf_chop_i = 1'b0;
  logic [2:0] col_i = 3'd0;
  logic       busy_o, beat_drive_o, wr_end_o;
  logic [2:0] beat_idx_o, beat_col_o;

  int nchk = 0;
  int nfail = 0;

  always #4 clk_i = ~clk_i;

  ddr_beat_order u_ddr_beat_order (
    .clk_i, .rst_ni, .start_i, .wr_i, .interleave_i, .bl_mode_i,
    .otf_chop_i, .col_i, .busy_o, .beat_idx_o, .beat_col_o,
    .beat_drive_o, .wr_end_o
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit is_chop(input bit [1:0] mode, input bit otf);
    return (mode == 2'd2) || (mode == 2'd1 && otf);
  endfunction

  function automatic int exp_col(input bit wr, input bit ilv, input bit [1:0] mode,
                                 input bit otf, input int c, input int k);
    bit ch = is_chop(mode, otf);
    if (ch && k >= 4) return 0;
    if (wr) return ch ? ((c / 4) * 4 + k) : k;
    if (ilv) return c ^ k;
    return ((((c / 4) + (k / 4)) % 2) * 4) + ((c % 4 + k) % 4);
  endfunction

  function automatic string col_tag(input bit wr, input bit ilv, input bit [1:0] mode, input bit otf);
    bit ch = is_chop(mode, otf);
    if (wr) return ch ? "R8" : "R7";
    if (ch) return "R6";
    return ilv ? "R5" : "R4";
  endfunction

  task automatic burst(input bit wr, input bit ilv, input bit [1:0] mode, input bit otf,
                       input bit [2:0] c, input bit inject, input string tag_over);
    string ct;
    int we_slot;
    ct = (tag_over != "") ? tag_over : col_tag(wr, ilv, mode, otf);
    we_slot = (mode == 2'd2) ? 5 : 7;
    @(negedge clk_i);
    chk("R10", "idle busy", int'(busy_o), 0);
    start_i = 1'b1; wr_i = wr; interleave_i = ilv; bl_mode_i = mode;
    otf_chop_i = otf; col_i = c;
    @(negedge clk_i);
    start_i = 1'b0;
    // scramble command inputs: latched values must hold (R2)
    wr_i = ~wr; interleave_i = ~ilv; bl_mode_i = ~mode; otf_chop_i = ~otf; col_i = ~c;
    for (int k = 0; k < 8; k++) begin
      chk("R1", "busy", int'(busy_o), 1);
      chk("R1", "idx", int'(beat_idx_o), k);
      chk(inject ? "R2" : ct, "col", int'(beat_col_o), exp_col(wr, ilv, mode, otf, int'(c), k));
      chk(inject ? "R2" : ct, "drive", int'(beat_drive_o),
          (is_chop(mode, otf) && k >= 4) ? 0 : 1);
      chk("R9", "wr_end", int'(wr_end_o), (wr && k == we_slot) ? 1 : 0);
      if (inject && k == 2) start_i = 1'b1;
      if (inject && k == 4) start_i = 1'b0;
      @(negedge clk_i);
    end
    chk("R1", "busy after", int'(busy_o), 0);
    chk("R10", "drive idle", int'(beat_drive_o), 0);
  endtask

  initial begin : main
    void'($urandom(32'd4711));
    #1;
    chk("R10", "rst busy", int'(busy_o), 0);
    chk("R10", "rst drive", int'(beat_drive_o), 0);
    chk("R10", "rst wr_end", int'(wr_end_o), 0);
    chk("R10", "rst col", int'(beat_col_o), 0);
    chk("R10", "rst idx", int'(beat_idx_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // directed cases
    burst(1'b0, 1'b0, 2'd0, 1'b0, 3'd1, 1'b0, "R4");
    burst(1'b0, 1'b1, 2'd0, 1'b0, 3'd5, 1'b0, "R5");
    burst(1'b0, 1'b0, 2'd2, 1'b0, 3'd6, 1'b0, "R6");
    burst(1'b0, 1'b1, 2'd1, 1'b1, 3'd3, 1'b0, "R6");
    burst(1'b1, 1'b1, 2'd0, 1'b0, 3'd7, 1'b0, "R7");
    burst(1'b1, 1'b0, 2'd2, 1'b0, 3'd5, 1'b0, "R8");
    burst(1'b1, 1'b0, 2'd1, 1'b1, 3'd6, 1'b0, "R8");
    burst(1'b1, 1'b0, 2'd1, 1'b0, 3'd2, 1'b0, "R3");
    burst(1'b0, 1'b0, 2'd3, 1'b1, 3'd3, 1'b0, "R3");
    burst(1'b1, 1'b1, 2'd3, 1'b0, 3'd4, 1'b0, "R3");
    burst(1'b0, 1'b0, 2'd0, 1'b0, 3'd2, 1'b1, "");
    burst(1'b1, 1'b0, 2'd2, 1'b0, 3'd4, 1'b1, "");
    // constrained random
    for (int n = 0; n < 60; n++) begin
      burst(1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
            ($urandom % 4) == 0, "");
    end
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin : watchdog
    #(8 * 200000);
    nchk++;
    nfail++;
    $display("FAIL watchdog run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule